// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

A purely combinational datapath slice that computes the next accumulator value and the next carry flag of a small 8-bit processor core. The surrounding datapath supplies the current accumulator, a second operand byte that it has already fetched, the current carry flag and a 4-bit operation code. The block returns the result byte and the updated carry in the same cycle. Writeback and operand selection stay outside.

The operations cover binary add with and without carry-in and subtract with borrow. They also cover increment and decrement, bitwise AND, OR and XOR, clear, complement and nibble exchange. The last group is the four single-bit rotates, two of which route through the carry flag. Operations that do not define a carry result hand the incoming carry through untouched. The data width is a parameter with a default of 8.

Top module: `acc_alu`

## Requirements
- R1: Code 4'd0 (add) returns acc+opnd modulo 256 and sets carry to the carry out of bit 7. The incoming carry has no effect on either output.
- R2: Code 4'd1 (add with carry) returns acc+opnd+carry_in modulo 256 and sets carry to the carry out of bit 7.
- R3: Code 4'd2 (subtract with borrow) returns acc-opnd-carry_in modulo 256 and sets carry to 1 exactly when that difference is negative, which is a borrow into bit 7.
- R4: Code 4'd3 returns acc+1 and code 4'd4 returns acc-1, both wrapping modulo 256. Carry passes through unchanged.
- R5: Codes 4'd5, 4'd6 and 4'd7 return the bitwise AND, OR and XOR of acc and opnd. Carry passes through unchanged.
- R6: Code 4'd8 returns zero and code 4'd9 returns the bitwise inverse of acc. Carry passes through unchanged for both.
- R7: Code 4'd10 returns acc with bits 7..4 and bits 3..0 exchanged. Carry passes through unchanged.
- R8: Code 4'd11 rotates left: bit n goes to bit n+1 and bit 7 goes to bit 0. Code 4'd13 rotates right: bit n+1 goes to bit n and bit 0 goes to bit 7. Carry passes through unchanged for both.
- R9: Code 4'd12 rotates left through carry: bit 7 becomes the new carry, and the old carry enters bit 0.
- R10: Code 4'd14 rotates right through carry: bit 0 becomes the new carry, and the old carry enters bit 7.
- R11: Code 4'd15 returns acc and carry unchanged. The operand byte has no effect on any operation except codes 0, 1, 2, 5, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand byte |
| cy_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| acc_o | output | 8 | Next accumulator value |
| cy_o | output | 1 | Next carry flag |

## Verification
The carry and borrow boundaries are the hardest cases to reach with uniform random bytes. These are sums landing exactly on 256, such as 0xFF+0x00 with carry-in, and differences landing exactly on -1, such as equal operands with borrow-in. The stimulus forces them with directed vectors at the extremes 0x00, 0x7F, 0x80 and 0xFF under both carry values. It then runs a long seeded random sweep over every code, which exercises the carry pass-through of the non-arithmetic operations under both carry states.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 8
) (
  input  logic [W-1:0] acc_i,
  input  logic [W-1:0] opnd_i,
  input  logic         cy_i,
  input  logic [3:0]   op_i,
  output logic [W-1:0] acc_o,
  output logic         cy_o
);
  localparam int H = W / 2;

  logic [W-1:0] res;
  logic         cy;
  logic [W:0]   sum;
  logic [W-1:0] cin_ext;

  assign cin_ext = {{(W-1){1'b0}}, cy_i};

  always_comb begin
    res = acc_i;
    cy  = cy_i;
    sum = '0;
    unique case (op_i)
      4'd0:  begin sum = {1'b0, acc_i} + {1'b0, opnd_i};                    {cy, res} = sum; end
      4'd1:  begin sum = {1'b0, acc_i} + {1'b0, opnd_i} + {1'b0, cin_ext};  {cy, res} = sum; end
      4'd2:  begin sum = {1'b0, acc_i} - {1'b0, opnd_i} - {1'b0, cin_ext};  {cy, res} = sum; end
      4'd3:  res = acc_i + 1'b1;
      4'd4:  res = acc_i - 1'b1;
      4'd5:  res = acc_i & opnd_i;
      4'd6:  res = acc_i | opnd_i;
      4'd7:  res = acc_i ^ opnd_i;
      4'd8:  res = '0;
      4'd9:  res = ~acc_i;
      4'd10: res = {acc_i[H-1:0], acc_i[W-1:H]};
      4'd11: res = {acc_i[W-2:0], acc_i[W-1]};
      4'd12: {cy, res} = {acc_i, cy_i};
      4'd13: res = {acc_i[0], acc_i[W-1:1]};
      4'd14: {res, cy} = {cy_i, acc_i};
      default: ;
    endcase

    if (op_i == 4'd0) assert_add_inverse_R1: assert (W'(res - opnd_i) == acc_i);
    if (op_i == 4'd1) assert_addc_inverse_R2: assert (W'(res - opnd_i - cin_ext) == acc_i);
    if (op_i == 4'd2) assert_sub_inverse_R3: assert (W'(res + opnd_i + cin_ext) == acc_i);
    if (op_i >= 4'd3 && op_i <= 4'd11 || op_i == 4'd13 || op_i == 4'd15)
      assert_carry_kept_R4: assert (cy == cy_i);
    if (op_i == 4'd9) assert_cpl_all_bits_R6: assert ((res ^ acc_i) == {W{1'b1}});
    if (op_i == 4'd10) assert_swap_weight_R7: assert ($countones(res) == $countones(acc_i));
    if (op_i == 4'd11 || op_i == 4'd13)
      assert_rot_weight_R8: assert ($countones(res) == $countones(acc_i));
    if (op_i == 4'd12 || op_i == 4'd14)
      assert_rotc_weight_R9: assert ($countones({cy, res}) == $countones({cy_i, acc_i}));
  end

  assign acc_o = res;
  assign cy_o  = cy;
endmodule

// File: tb/acc_alu_tb.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [7:0] acc, opnd, acc_o;
  logic       cy, cy_o;
  logic [3:0] op;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  acc_alu dut_i (.acc_i(acc), .opnd_i(opnd), .cy_i(cy), .op_i(op), .acc_o(acc_o), .cy_o(cy_o));

  function automatic logic [8:0] ref_model(input logic [3:0] o, input logic [7:0] a,
                                           input logic [7:0] b, input logic c);
    int s;
    case (o)
      4'd0:  begin s = a + b;     return {s > 255, 8'(s)}; end
      4'd1:  begin s = a + b + c; return {s > 255, 8'(s)}; end
      4'd2:  begin s = a - b - c; return {s < 0,   8'(s)}; end
      4'd3:  return {c, 8'(a + 1)};
      4'd4:  return {c, 8'(a - 1)};
      4'd5:  return {c, a & b};
      4'd6:  return {c, a | b};
      4'd7:  return {c, a ^ b};
      4'd8:  return {c, 8'h00};
      4'd9:  return {c, 8'hFF - a};
      4'd10: return {c, a[3:0], a[7:4]};
      4'd11: return {c, a[6:0], a[7]};
      4'd12: return {a[7], a[6:0], c};
      4'd13: return {c, a[0], a[7:1]};
      4'd14: return {a[0], c, a[7:1]};
      default: return {c, a};
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";  4'd1: return "R2";  4'd2: return "R3";
      4'd3, 4'd4: return "R4";
      4'd5, 4'd6, 4'd7: return "R5";
      4'd8, 4'd9: return "R6";
      4'd10: return "R7";
      4'd11, 4'd13: return "R8";
      4'd12: return "R9";
      4'd14: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic run(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [8:0] exp;
    @(negedge clk);
    op = o; acc = a; opnd = b; cy = c;
    #1;
    exp = ref_model(o, a, b, c);
    checks++;
    if ({cy_o, acc_o} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h c=%b actual cy=%b acc=%h expected cy=%b acc=%h",
               req_of(o), o, a, b, c, cy_o, acc_o, exp[8], exp[7:0]);
    end
  endtask

  initial begin
    acc = '0; opnd = '0; cy = 1'b0; op = 4'd15;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({cy_o, acc_o} !== 9'h000) begin
      fails++;
      $display("FAIL R11 idle actual %h expected 000", {cy_o, acc_o});
    end
    // R1: carry-in ignored, exact wrap to 256
    run(4'd0, 8'hFF, 8'h01, 1'b1);
    run(4'd0, 8'hFF, 8'h00, 1'b1);
    run(4'd0, 8'h7F, 8'h80, 1'b0);
    // R2: carry-in lands the sum on 256
    run(4'd1, 8'hFF, 8'h00, 1'b1);
    run(4'd1, 8'hFF, 8'hFF, 1'b1);
    run(4'd1, 8'h7F, 8'h80, 1'b0);
    // R3: equal operands with borrow-in give -1
    run(4'd2, 8'h80, 8'h80, 1'b1);
    run(4'd2, 8'h80, 8'h80, 1'b0);
    run(4'd2, 8'h00, 8'hFF, 1'b0);
    // R4: wrap both ways, carry kept
    run(4'd3, 8'hFF, 8'h00, 1'b0);
    run(4'd4, 8'h00, 8'h00, 1'b1);
    // R5..R10 directed
    run(4'd5, 8'hF0, 8'h3C, 1'b1);
    run(4'd6, 8'hF0, 8'h3C, 1'b0);
    run(4'd7, 8'hF0, 8'h3C, 1'b1);
    run(4'd8, 8'hA5, 8'hFF, 1'b1);
    run(4'd9, 8'hA5, 8'h00, 1'b0);
    run(4'd10, 8'h1E, 8'h00, 1'b1);
    run(4'd11, 8'h81, 8'h00, 1'b0);
    run(4'd13, 8'h81, 8'h00, 1'b1);
    run(4'd12, 8'h80, 8'h00, 1'b0);
    run(4'd12, 8'h01, 8'h00, 1'b1);
    run(4'd14, 8'h01, 8'h00, 1'b0);
    run(4'd14, 8'h80, 8'h00, 1'b1);
    // R11: pass-through ignores operand
    run(4'd15, 8'h5A, 8'hFF, 1'b1);
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++)
      run(4'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule